// File: doc/BRIEF.md
# Fractional-N Divider Sequencer

This block generates the division sequence for the loop of a fractional-N synthesizer that uses an external dual-modulus prescaler. It drives the prescaler's modulus-select line and counts the prescaler's output pulses into a divided main pulse. It also divides a reference tick stream by a programmable ratio to produce the comparison pulse. Over time the main ratio averages P·M + A + F/32, where P is the prescaler's lower modulus. P is 32 (pair 32/33) or 16 (pair 16/17) and is fixed by a parameter for each instance.

The design runs in one system clock domain. The prescaler output and the reference are each presented as a one-clock-wide tick. A load strobe offers a new set of M, A, F and R values, plus a 3-bit code for the maximum fractionality. Each set is checked before it is accepted. A set that passes is held in shadow registers. Each divider picks it up only at its own next cycle boundary. A set that fails raises the error flag and is thrown away.

Top module: `fracn_divider`

## Requirements
- R1: While reset is high, and after it until a valid set has been loaded, mod_ctl, main_out, ref_out and cfg_err are all 0.
- R2: Once an R value is active, ref_out pulses high for exactly one clock after every R-th ref_tick. R may be any value from 3 to 511, including both limits.
- R3: A load with R below 3 or above 511 sets cfg_err to 1 on the clock after the strobe.
- R4: The code mf_in = k (0..5) selects a maximum fractionality of 2^k. F is legal only when its low 5−k bits are zero, so code 0 allows only F = 0 and code 5 allows any F. An illegal F, or a code of 6 or 7, sets cfg_err.
- R5: A load sets cfg_err when M = 0, when A > M, when A ≥ P, or when A = M and F ≠ 0.
- R6: Each main cycle spans exactly M prescaler ticks. mod_ctl = 1 selects modulus P+1 and 0 selects P. The value of mod_ctl at each tick names the modulus of the prescaler period that tick ends. mod_ctl is 1 for the first A′ ticks and 0 for the rest. main_out pulses for one clock after the M-th tick.
- R7: At each main cycle boundary, a 5-bit accumulator adds F. A′ = A + carry-out. Any 32 consecutive cycles therefore total 32·(P·M + A) + F prescaler input periods.
- R8: Values taken at a load apply only from the next boundary of each divider. The cycle in progress completes entirely with the old values.
- R9: cfg_err is updated on every load strobe, and a legal load clears it.
- R10: A rejected load leaves the active and pending M, A, F and R unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 1 | One-clock pulse per prescaler output edge |
| ref_tick | input | 1 | One-clock pulse per reference edge |
| m_in | input | M_W (10) | Main counter value M |
| a_in | input | PRE_LOG2+1 (6) | Swallow count A |
| f_in | input | 5 | Fraction numerator F (of 32) |
| r_in | input | R_W (10) | Reference divide ratio R |
| mf_in | input | 3 | Max-fractionality code k (2^k) |
| load | input | 1 | Offers the set on the value inputs |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = P+1 |
| main_out | output | 1 | Divided main pulse |
| ref_out | output | 1 | Divided reference (comparison) pulse |
| cfg_err | output | 1 | Last offered set was rejected |

## Verification
The bench weights every prescaler tick by the modulus shown on mod_ctl and sums those weights per main cycle. It compares each sum with a model of P·M + A + carry. Four configurations are run: an integer one with F = 0, a coarse fraction (F = 8 under fractionality 4), a fraction with F = 31 next to the largest legal A, and a half fraction with A = 0, where the carry alone raises the modulus. Together these separate swallow counting from accumulator wrap. Each new set is loaded at the start of a cycle, so an early switch shows up in that cycle's sum. Illegal sets offered in the middle of a run must leave both the running sums and the reference period unchanged.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int FRAC_W = 5;

  // F legal for fractionality 2^code: low (FRAC_W-code) bits must be zero
  function automatic logic frac_ok(input logic [FRAC_W-1:0] f, input logic [2:0] code);
    logic [FRAC_W-1:0] mask;
    if (code > 3'd5) return 1'b0;
    mask = {FRAC_W{1'b1}} >> code;
    return (f & mask) == '0;
  endfunction
endpackage

// File: rtl/fracn_cfg_check.sv
module fracn_cfg_check #(
  parameter int M_W   = 10,
  parameter int A_W   = 6,
  parameter int R_W   = 10,
  parameter int P_LO  = 32,
  parameter int R_MIN = 3,
  parameter int R_MAX = 511
) (
  input  logic [M_W-1:0]               m,
  input  logic [A_W-1:0]               a,
  input  logic [fracn_pkg::FRAC_W-1:0] f,
  input  logic [R_W-1:0]               r,
  input  logic [2:0]                   mf,
  output logic                         bad
);
  logic [M_W-1:0] a_ext;
  logic r_bad, m_bad, f_bad;

  always_comb begin
    a_ext = M_W'(a);
    r_bad = (r < R_W'(R_MIN)) || (r > R_W'(R_MAX));
    f_bad = !fracn_pkg::frac_ok(f, mf);
    m_bad = (m == '0) || (a_ext > m) || (a >= A_W'(P_LO)) ||
            ((a_ext == m) && (f != '0));
    bad   = r_bad || f_bad || m_bad;
  end
endmodule

// File: rtl/fracn_ref_div.sv
module fracn_ref_div #(
  parameter int R_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           ld,
  input  logic [R_W-1:0] r_new,
  output logic           out
);
  logic [R_W-1:0] r_pend, r_act, cnt;
  logic           pend, run;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_pend <= '0;
      r_act  <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      run    <= 1'b0;
      out    <= 1'b0;
    end else begin
      out <= 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          if (pend) begin
            r_act <= r_pend;
            cnt   <= r_pend - 1'b1;
            run   <= 1'b1;
            pend  <= 1'b0;
          end else if (run) begin
            cnt <= r_act - 1'b1;
          end
          out <= run;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (ld) begin
        r_pend <= r_new;
        pend   <= 1'b1;
      end
    end
  end

  // pulse only follows a reference tick
  assert_ref_src_R2: assert property (@(posedge clk) disable iff (rst)
    out |-> $past(tick));
  // single-clock pulse when ticks are spaced
  assert_ref_width_R2: assert property (@(posedge clk) disable iff (rst)
    (out && !tick) |=> !out);
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div #(
  parameter int M_W = 10,
  parameter int A_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         ld,
  input  logic [M_W-1:0]               m_new,
  input  logic [A_W-1:0]               a_new,
  input  logic [fracn_pkg::FRAC_W-1:0] f_new,
  output logic                         mod_hi,
  output logic                         out
);
  localparam int FW = fracn_pkg::FRAC_W;

  logic [M_W-1:0] m_pend, m_act, sel_m, pcnt, pcnt_inc;
  logic [A_W-1:0] a_pend, a_act, sel_a;
  logic [FW-1:0]  f_pend, f_act, sel_f, acc;
  logic [FW:0]    acc_sum;
  logic [A_W:0]   swal, swal_nxt;
  logic           pend, run, last;

  always_comb begin
    sel_m    = pend ? m_pend : m_act;
    sel_a    = pend ? a_pend : a_act;
    sel_f    = pend ? f_pend : f_act;
    acc_sum  = {1'b0, acc} + {1'b0, sel_f};
    swal_nxt = {1'b0, sel_a} + {{A_W{1'b0}}, acc_sum[FW]};
    pcnt_inc = pcnt + 1'b1;
    last     = !run || (pcnt == m_act - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; a_pend <= '0; f_pend <= '0; pend <= 1'b0;
      m_act  <= '0; a_act  <= '0; f_act  <= '0;
      pcnt   <= '0; swal   <= '0; acc    <= '0;
      run    <= 1'b0; mod_hi <= 1'b0; out <= 1'b0;
    end else begin
      out <= 1'b0;
      if (tick) begin
        if (last) begin
          if (pend || run) begin
            acc    <= acc_sum[FW-1:0];
            swal   <= swal_nxt;
            mod_hi <= (swal_nxt != '0);
            pcnt   <= '0;
            run    <= 1'b1;
            out    <= run;
            m_act  <= sel_m;
            a_act  <= sel_a;
            f_act  <= sel_f;
            pend   <= 1'b0;
          end
        end else begin
          pcnt   <= pcnt_inc;
          mod_hi <= (pcnt_inc < M_W'(swal));
        end
      end
      if (ld) begin
        m_pend <= m_new;
        a_pend <= a_new;
        f_pend <= f_new;
        pend   <= 1'b1;
      end
    end
  end

  // modulus select only moves on a prescaler tick
  assert_mod_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mod_hi));
  // divided pulse only follows a prescaler tick
  assert_main_src_R6: assert property (@(posedge clk) disable iff (rst)
    out |-> $past(tick));
  // swallow count with carry never exceeds the cycle length
  assert_swallow_bound_R7: assert property (@(posedge clk) disable iff (rst)
    run |-> (M_W'(swal) <= m_act));
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider #(
  parameter  int PRE_LOG2 = 5,
  parameter  int M_W      = 10,
  parameter  int R_W      = 10,
  localparam int A_W      = PRE_LOG2 + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pre_tick,
  input  logic                         ref_tick,
  input  logic [M_W-1:0]               m_in,
  input  logic [A_W-1:0]               a_in,
  input  logic [fracn_pkg::FRAC_W-1:0] f_in,
  input  logic [R_W-1:0]               r_in,
  input  logic [2:0]                   mf_in,
  input  logic                         load,
  output logic                         mod_ctl,
  output logic                         main_out,
  output logic                         ref_out,
  output logic                         cfg_err
);
  localparam int P_LO  = 1 << PRE_LOG2;
  localparam int R_MIN = 3;
  localparam int R_MAX = 511;

  logic bad, ld_ok;

  fracn_cfg_check #(.M_W(M_W), .A_W(A_W), .R_W(R_W), .P_LO(P_LO),
                    .R_MIN(R_MIN), .R_MAX(R_MAX)) u_check (
    .m(m_in), .a(a_in), .f(f_in), .r(r_in), .mf(mf_in), .bad(bad));

  assign ld_ok = load && !bad;

  always_ff @(posedge clk) begin
    if (rst)       cfg_err <= 1'b0;
    else if (load) cfg_err <= bad;
  end

  fracn_main_div #(.M_W(M_W), .A_W(A_W)) u_main (
    .clk(clk), .rst(rst), .tick(pre_tick), .ld(ld_ok),
    .m_new(m_in), .a_new(a_in), .f_new(f_in),
    .mod_hi(mod_ctl), .out(main_out));

  fracn_ref_div #(.R_W(R_W)) u_ref (
    .clk(clk), .rst(rst), .tick(ref_tick), .ld(ld_ok),
    .r_new(r_in), .out(ref_out));

  assert_low_r_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (load && (r_in < R_W'(R_MIN))) |=> cfg_err);
  assert_bad_code_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (load && (mf_in > 3'd5)) |=> cfg_err);
  assert_zero_m_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (load && (m_in == '0)) |=> cfg_err);
  assert_err_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_err));
endmodule

// File: tb/tb_fracn_divider.sv
module tb_fracn_divider;
  localparam int PL = 5, P = 32, MW = 10, AW = 6, RW = 10;

  logic clk = 0, rst = 1, pre_tick = 0, ref_tick = 0, load = 0;
  logic [MW-1:0] m_in = '0;
  logic [AW-1:0] a_in = '0;
  logic [4:0]    f_in = '0;
  logic [RW-1:0] r_in = '0;
  logic [2:0]    mf_in = '0;
  logic mod_ctl, main_out, ref_out, cfg_err;

  fracn_divider #(.PRE_LOG2(PL), .M_W(MW), .R_W(RW)) dut (
    .clk(clk), .rst(rst), .pre_tick(pre_tick), .ref_tick(ref_tick),
    .m_in(m_in), .a_in(a_in), .f_in(f_in), .r_in(r_in), .mf_in(mf_in),
    .load(load), .mod_ctl(mod_ctl), .main_out(main_out),
    .ref_out(ref_out), .cfg_err(cfg_err));

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct { int tot; int id; string req; } item_t;
  item_t exp_q[$];
  int grand[5] = '{default: 0};
  int acc_m = 0;

  function automatic int next_total(int m, int a, int f);
    int s, c;
    s = acc_m + f;
    c = (s >= 32) ? 1 : 0;
    acc_m = s % 32;
    return P * m + a + c;
  endfunction

  // scoreboard monitor
  int sum = 0, ref_cnt = 0, ref_period = 0, ref_pulses = 0;
  bit armed = 0, last_main = 0, last_ref = 0;
  always @(negedge clk) begin
    item_t it;
    if (rst) begin
      sum = 0; armed = 0; ref_cnt = 0;
    end else begin
      if (main_out) begin
        if (last_main) check("R6 main_out width", 2, 1);
        if (armed && exp_q.size() > 0) begin
          it = exp_q.pop_front();
          check(it.req, sum, it.tot);
          grand[it.id] += sum;
        end
        armed = 1;
        sum = 0;
      end
      if (pre_tick) sum += mod_ctl ? P + 1 : P;
      last_main = main_out;
      if (ref_out) begin
        if (last_ref) check("R2 ref_out width", 2, 1);
        ref_period = ref_cnt;
        ref_cnt = 0;
        ref_pulses++;
      end
      if (ref_tick) ref_cnt++;
      last_ref = ref_out;
    end
  end

  // tick generators
  initial begin
    wait (rst == 0);
    for (int g = 0; ; g++) begin
      repeat (1 + (g % 2)) @(posedge clk);
      #2 pre_tick = 1;
      @(posedge clk);
      #2 pre_tick = 0;
    end
  end
  initial begin
    wait (rst == 0);
    forever begin
      repeat (2) @(posedge clk);
      #2 ref_tick = 1;
      @(posedge clk);
      #2 ref_tick = 0;
    end
  end

  task automatic load_cfg(int m, int a, int f, int r, int mf);
    @(posedge clk);
    #2;
    m_in = MW'(m); a_in = AW'(a); f_in = 5'(f); r_in = RW'(r); mf_in = 3'(mf);
    load = 1;
    @(posedge clk);
    #2 load = 0;
    @(negedge clk);
  endtask

  task automatic push(int m, int a, int f, int n, int id, string req);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.tot = next_total(m, a, f);
      it.id = id;
      it.req = req;
      exp_q.push_back(it);
    end
  endtask

  task automatic wait_q(int n);
    while (exp_q.size() > n) @(negedge clk);
  endtask

  task automatic measure_ref(int exp, string req);
    int start;
    start = ref_pulses;
    while (ref_pulses < start + 3) @(negedge clk);
    check(req, ref_period, exp);
  endtask

  task automatic bad_load(int m, int a, int f, int r, int mf, string req);
    load_cfg(m, a, f, r, mf);
    check(req, cfg_err, 1);
  endtask

  initial begin
    int quiet;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 mod_ctl in reset", mod_ctl, 0);
    check("R1 main_out in reset", main_out, 0);
    check("R1 ref_out in reset", ref_out, 0);
    check("R1 cfg_err in reset", cfg_err, 0);
    @(posedge clk);
    #2 rst = 0;
    quiet = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      quiet += mod_ctl + main_out + ref_out + cfg_err;
    end
    check("R1 outputs idle before first load", quiet, 0);

    // run 1: integer ratio, minimum legal R
    load_cfg(5, 3, 0, 3, 5);
    check("R9 legal load err", cfg_err, 0);
    void'(next_total(5, 3, 0));
    push(5, 3, 0, 4, 1, "R6 integer cycle total");
    measure_ref(3, "R2 ref period R=3");
    wait_q(1);

    // run 2: F=8 under fractionality 4
    load_cfg(6, 2, 8, 7, 2);
    check("R9 legal load err run2", cfg_err, 0);
    push(6, 2, 8, 1, 2, "R8 first cycle after switch F=8");
    push(6, 2, 8, 31, 2, "R7 cycle total F=8");
    measure_ref(7, "R2 ref period R=7");
    wait_q(1);

    // run 3: F=31, A near P, with rejected loads in flight
    load_cfg(33, 31, 31, 300, 5);
    push(33, 31, 31, 1, 3, "R8 first cycle after switch F=31");
    push(33, 31, 31, 63, 3, "R7 R10 cycle total F=31");
    bad_load(33, 31, 31, 2, 5, "R3 R=2 flagged");
    bad_load(33, 31, 31, 600, 5, "R3 R=600 flagged");
    bad_load(33, 31, 31, 300, 6, "R4 code 6 flagged");
    bad_load(33, 31, 1, 300, 4, "R4 F=1 at fractionality 16 flagged");
    bad_load(33, 31, 16, 300, 0, "R4 F nonzero at fractionality 1 flagged");
    bad_load(5, 10, 0, 300, 5, "R5 A>M flagged");
    bad_load(0, 0, 0, 300, 5, "R5 M=0 flagged");
    bad_load(5, 5, 4, 300, 5, "R5 A=M with F flagged");
    bad_load(40, 32, 0, 300, 5, "R5 A>=P flagged");
    measure_ref(300, "R10 R unchanged after rejected loads");
    wait_q(1);

    // run 4: A=0, half fraction, maximum R
    load_cfg(4, 0, 16, 511, 1);
    check("R9 legal load clears err", cfg_err, 0);
    push(4, 0, 16, 1, 4, "R8 first cycle after switch F=16");
    push(4, 0, 16, 7, 4, "R7 carry-only swallow F=16");
    measure_ref(511, "R2 ref period R=511");
    wait_q(0);

    check("R7 32-cycle sum F=8", grand[2], 32 * (P * 6 + 2) + 8);
    check("R7 64-cycle sum F=31", grand[3], 2 * (32 * (P * 33 + 31) + 31));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule